// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block is the priority core of one processor's local interrupt controller. It keeps three 256-entry bit vectors (pending requests, vectors in service, and the trigger mode captured for each request) and from them and a programmable task priority it works out the processor priority. When the controller is enabled and the best pending request is in a higher priority class (the upper four bits of the vector) than the processor priority, the interrupt line to the processor goes high.

An interrupt source injects a vector with its trigger mode. The processor acknowledges, gets the best pending vector back and moves it into service in the same cycle. Later it retires the most important in-service vector by writing the end-of-interrupt offset. A 32-bit register port indexed by word offset reads the vectors and priorities and programs the task priority and the enable register. An access to an offset outside the map sets a sticky error flag.

Top module: `lapic_prio_ctrl`

## Requirements
- R1: After reset the task priority reads 0x00, the enable register (offset 0x0f) reads 0x0ff, the error register (offset 0x28) reads 0, all three vectors read zero and `irq` is low.
- R2: An injection of vector v sets request bit v and sets trigger-mode bit v to 1 for level or 0 for edge. Bit v sits at bit v%32 of word v/32. Request words read at offsets 0x20+w and trigger-mode words at 0x18+w.
- R3: The highest set index of a vector selects its best entry. An empty vector counts as priority 0.
- R4: The processor priority (read-only, offset 0x0a) equals the task priority when the task class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it is that in-service class in bits 7:4 with bits 3:0 zero.
- R5: `irq` is high exactly when bit 8 of the enable register is set, a request is pending, and the class of the highest pending vector is strictly greater than bits 7:4 of the processor priority. It follows the state with no extra register, so it changes in the cycle after the edge that changed the state.
- R6: An acknowledge while enabled with a request pending returns the highest pending vector with `ack_spurious` low. At the same clock edge it clears that request bit and sets its in-service bit (in-service words read at 0x10+w).
- R7: An acknowledge while disabled or with nothing pending returns `ack_spurious` high with `ack_vector` equal to bits 7:0 of the enable register, and changes no state.
- R8: A write to offset 0x0b clears the highest in-service bit and does nothing when none is set. A read of 0x0b returns 0.
- R9: The task priority (offset 0x08, 8 bits) and the enable register (offset 0x0f, bits 8:0) are read/write. Their upper read bits are zero.
- R10: A read or write at any offset other than 0x08, 0x0a, 0x0b, 0x0f and 0x10 to 0x28 sets error bit 7, which holds until reset. Such a read returns 0.
- R11: Writes to the read-only offsets 0x0a and 0x10 to 0x28 change nothing and raise no error.
- R12: In one cycle an injection of the vector being acknowledged leaves its request bit set. An end-of-interrupt together with an acknowledge clears the old in-service bit before it sets the acknowledged one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_ofs | input | 8 | Word offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, zero when no read |
| inj_valid | input | 1 | Inject a vector this cycle |
| inj_vector | input | 8 | Vector to inject |
| inj_level | input | 1 | 1 level-triggered, 0 edge-triggered |
| ack_req | input | 1 | Acknowledge strobe |
| ack_vector | output | 8 | Acknowledged vector, or spurious vector |
| ack_spurious | output | 1 | Acknowledge found nothing to deliver |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The assertions take every input to be known after reset. They also take each strobe (read, write, inject, acknowledge) to describe one event in the cycle where it is high, so a strobe held for two cycles counts as two events. They assume nothing about how the strobes combine, because the block defines the same-cycle cases itself. The stimulus therefore drives each operation for exactly one clock. In directed steps it combines injection, acknowledge and end-of-interrupt in one cycle. The random phase ranges over the whole vector space, the whole task priority range, both enable states and offsets inside and outside the map.

// File: rtl/lapic_pkg.sv
package lapic_pkg;

  localparam int PRIO_W = 8;
  localparam int CLS_W  = 4;

  // Word offsets of the register map
  localparam logic [7:0] OFS_TPR  = 8'h08;
  localparam logic [7:0] OFS_PPR  = 8'h0a;
  localparam logic [7:0] OFS_EOI  = 8'h0b;
  localparam logic [7:0] OFS_SVR  = 8'h0f;
  localparam logic [7:0] OFS_ISR0 = 8'h10;
  localparam logic [7:0] OFS_TMR0 = 8'h18;
  localparam logic [7:0] OFS_IRR0 = 8'h20;
  localparam logic [7:0] OFS_ESR  = 8'h28;

  localparam int SVR_W      = 9;
  localparam int SVR_EN_BIT = 8;
  localparam int ESR_W      = 8;
  localparam int ESR_ILL    = 7;

  typedef enum logic [2:0] {
    RG_NONE, RG_TPR, RG_PPR, RG_EOI, RG_SVR, RG_ISR, RG_TMR, RG_IRR
  } reg_sel_e;

  function automatic logic [CLS_W-1:0] prio_class(input logic [PRIO_W-1:0] v);
    return v[PRIO_W-1 -: CLS_W];
  endfunction

  function automatic logic [PRIO_W-1:0] calc_ppr(input logic [PRIO_W-1:0] tpr,
                                                 input logic isr_any,
                                                 input logic [PRIO_W-1:0] isr_top);
    logic [CLS_W-1:0] icls;
    icls = isr_any ? prio_class(isr_top) : '0;
    if (prio_class(tpr) >= icls) return tpr;
    return {icls, {(PRIO_W-CLS_W){1'b0}}};
  endfunction

  function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
    if (ofs == OFS_TPR) return RG_TPR;
    if (ofs == OFS_PPR) return RG_PPR;
    if (ofs == OFS_EOI) return RG_EOI;
    if (ofs == OFS_SVR) return RG_SVR;
    if (ofs[7:3] == OFS_ISR0[7:3]) return RG_ISR;
    if (ofs[7:3] == OFS_TMR0[7:3]) return RG_TMR;
    if (ofs[7:3] == OFS_IRR0[7:3]) return RG_IRR;
    return RG_NONE;
  endfunction

endpackage

// File: rtl/lapic_hi_find.sv
module lapic_hi_find #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 8
) (
  input  logic [WORD_W*N_WORDS-1:0]         vec,
  output logic                              any,
  output logic [$clog2(WORD_W*N_WORDS)-1:0] top
);
  localparam int IDX_W = $clog2(WORD_W*N_WORDS);
  localparam int BIT_W = $clog2(WORD_W);

  logic             w_any [N_WORDS];
  logic [BIT_W-1:0] w_top [N_WORDS];

  // Per-word scan, then a word-level scan; later (higher) hits win.
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic             hit;
    logic [BIT_W-1:0] pos;
    always_comb begin
      hit = 1'b0;
      pos = '0;
      for (int b = 0; b < WORD_W; b++) begin
        if (vec[w*WORD_W + b]) begin
          hit = 1'b1;
          pos = BIT_W'(b);
        end
      end
    end
    assign w_any[w] = hit;
    assign w_top[w] = pos;
  end

  always_comb begin
    any = 1'b0;
    top = '0;
    for (int w = 0; w < N_WORDS; w++) begin
      if (w_any[w]) begin
        any = 1'b1;
        top = IDX_W'(w*WORD_W) | IDX_W'(w_top[w]);
      end
    end
  end
endmodule

// File: rtl/lapic_vec_state.sv
module lapic_vec_state #(
  parameter int VEC_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [VEC_W-1:0]    set_vec,
  input  logic                set_level,
  input  logic                ack_en,
  input  logic [VEC_W-1:0]    ack_vec,
  input  logic                eoi_en,
  input  logic [VEC_W-1:0]    eoi_vec,
  output logic [(1<<VEC_W)-1:0] irr,
  output logic [(1<<VEC_W)-1:0] isr,
  output logic [(1<<VEC_W)-1:0] tmr
);
  localparam int NUM_VEC = 1 << VEC_W;

  logic [NUM_VEC-1:0] irr_n, isr_n, tmr_n;

  always_comb begin
    irr_n = irr;
    isr_n = isr;
    tmr_n = tmr;
    // acknowledge clears first so a same-cycle injection re-sets the bit
    if (ack_en) irr_n[ack_vec] = 1'b0;
    if (set_en) begin
      irr_n[set_vec] = 1'b1;
      tmr_n[set_vec] = set_level;
    end
    // retire the old in-service entry before the acknowledged one enters
    if (eoi_en) isr_n[eoi_vec] = 1'b0;
    if (ack_en) isr_n[ack_vec] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr <= '0;
      isr <= '0;
      tmr <= '0;
    end else begin
      irr <= irr_n;
      isr <= isr_n;
      tmr <= tmr_n;
    end
  end
endmodule

// File: rtl/lapic_prio_ctrl.sv
module lapic_prio_ctrl
  import lapic_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int WORD_W = 32,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [OFS_W-1:0]  reg_ofs,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              inj_valid,
  input  logic [VEC_W-1:0]  inj_vector,
  input  logic              inj_level,
  input  logic              ack_req,
  output logic [VEC_W-1:0]  ack_vector,
  output logic              ack_spurious,
  output logic              irq
);
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int N_WORDS = NUM_VEC / WORD_W;
  localparam int WSEL_W  = $clog2(N_WORDS);

  logic [NUM_VEC-1:0] irr, isr, tmr;
  logic               irr_any, isr_any;
  logic [VEC_W-1:0]   irr_top, isr_top;
  logic [PRIO_W-1:0]  tpr_q, ppr;
  logic [SVR_W-1:0]   svr_q;
  logic [ESR_W-1:0]   esr_q;
  logic               svr_en;
  reg_sel_e           sel;
  logic [WSEL_W-1:0]  wsel;

  // named internal events
  logic ack_fire, eoi_fire, acc_illegal;

  lapic_hi_find #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_find_irr (
    .vec(irr), .any(irr_any), .top(irr_top)
  );
  lapic_hi_find #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_find_isr (
    .vec(isr), .any(isr_any), .top(isr_top)
  );

  assign sel         = decode_ofs(8'(reg_ofs));
  assign wsel        = reg_ofs[WSEL_W-1:0];
  assign svr_en      = svr_q[SVR_EN_BIT];
  assign ppr         = calc_ppr(tpr_q, isr_any, isr_top);
  assign acc_illegal = (reg_rd || reg_wr) && (sel == RG_NONE) && (8'(reg_ofs) != OFS_ESR);
  assign ack_fire    = ack_req && svr_en && irr_any;
  assign eoi_fire    = reg_wr && (sel == RG_EOI) && isr_any;

  lapic_vec_state #(.VEC_W(VEC_W)) u_state (
    .clk(clk), .rst_n(rst_n),
    .set_en(inj_valid), .set_vec(inj_vector), .set_level(inj_level),
    .ack_en(ack_fire), .ack_vec(irr_top),
    .eoi_en(eoi_fire), .eoi_vec(isr_top),
    .irr(irr), .isr(isr), .tmr(tmr)
  );

  assign ack_vector   = ack_fire ? irr_top : svr_q[VEC_W-1:0];
  assign ack_spurious = ack_req && !ack_fire;
  assign irq = svr_en && irr_any && (prio_class(irr_top) > prio_class(ppr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpr_q <= '0;
      svr_q <= SVR_W'(9'h0ff);
      esr_q <= '0;
    end else begin
      if (reg_wr && sel == RG_TPR) tpr_q <= reg_wdata[PRIO_W-1:0];
      if (reg_wr && sel == RG_SVR) svr_q <= reg_wdata[SVR_W-1:0];
      if (acc_illegal) esr_q[ESR_ILL] <= 1'b1;
    end
  end

  logic [WORD_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (sel)
      RG_TPR: rd_mux = WORD_W'(tpr_q);
      RG_PPR: rd_mux = WORD_W'(ppr);
      RG_SVR: rd_mux = WORD_W'(svr_q);
      RG_ISR: rd_mux = isr[wsel*WORD_W +: WORD_W];
      RG_TMR: rd_mux = tmr[wsel*WORD_W +: WORD_W];
      RG_IRR: rd_mux = irr[wsel*WORD_W +: WORD_W];
      default: rd_mux = (8'(reg_ofs) == OFS_ESR) ? WORD_W'(esr_q) : '0;
    endcase
  end
  assign reg_rdata = reg_rd ? rd_mux : '0;

endmodule

// File: rtl/lapic_prio_ctrl_chk.sv
module lapic_prio_ctrl_chk #(
  parameter int VEC_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  inj_valid,
  input logic [VEC_W-1:0]      inj_vector,
  input logic                  inj_level,
  input logic                  ack_req,
  input logic                  ack_fire,
  input logic [VEC_W-1:0]      ack_vector,
  input logic                  ack_spurious,
  input logic                  eoi_fire,
  input logic [VEC_W-1:0]      isr_top,
  input logic                  isr_any,
  input logic                  irr_any,
  input logic                  irq,
  input logic                  svr_en,
  input logic [7:0]            tpr_q,
  input logic [7:0]            ppr,
  input logic [(1<<VEC_W)-1:0] irr,
  input logic [(1<<VEC_W)-1:0] isr,
  input logic [(1<<VEC_W)-1:0] tmr,
  input logic [7:0]            esr_q,
  input logic                  acc_illegal
);
  AST_INJ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |=> irr[$past(inj_vector)] && (tmr[$past(inj_vector)] == $past(inj_level))); // R2
  AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    ppr >= tpr_q); // R4
  AST_PPR_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    isr_any |-> ppr[7:4] >= isr_top[VEC_W-1 -: 4]); // R4
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (svr_en && irr_any)); // R5
  AST_ACK_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> isr[$past(ack_vector)]); // R6
  AST_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !(inj_valid && inj_vector == ack_vector)) |=> !irr[$past(ack_vector)]); // R6
  AST_ACK_SPUR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !svr_en) |-> ack_spurious); // R7
  AST_EOI_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && !(ack_fire && ack_vector == isr_top)) |=> !isr[$past(isr_top)]); // R8
  AST_ILL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    acc_illegal |=> esr_q[7]); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    esr_q[7] |=> esr_q[7]); // R10
  AST_INJ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && inj_valid && inj_vector == ack_vector) |=> irr[$past(ack_vector)]); // R12
endmodule

bind lapic_prio_ctrl lapic_prio_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .inj_valid(inj_valid), .inj_vector(inj_vector), .inj_level(inj_level),
  .ack_req(ack_req), .ack_fire(ack_fire), .ack_vector(ack_vector),
  .ack_spurious(ack_spurious), .eoi_fire(eoi_fire),
  .isr_top(isr_top), .isr_any(isr_any), .irr_any(irr_any),
  .irq(irq), .svr_en(svr_en), .tpr_q(tpr_q), .ppr(ppr),
  .irr(irr), .isr(isr), .tmr(tmr), .esr_q(esr_q), .acc_illegal(acc_illegal)
);

// File: tb/lapic_prio_ctrl_test.sv
module lapic_prio_ctrl_test;
  logic        clk = 0, rst_n = 0;
  logic        reg_rd = 0, reg_wr = 0;
  logic [7:0]  reg_ofs = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        inj_valid = 0, inj_level = 0, ack_req = 0;
  logic [7:0]  inj_vector = 0, ack_vector;
  logic        ack_spurious, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  lapic_prio_ctrl uut (.*);

  always #2 clk = ~clk;

  // reference state
  logic [255:0] m_irr, m_isr, m_tmr;
  logic [7:0]   m_tpr, m_esr;
  logic [8:0]   m_svr;

  function automatic int m_hi(input logic [255:0] v);
    for (int i = 255; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int m_ppr();
    int hs = m_hi(m_isr);
    int ic = (hs < 0) ? 0 : hs / 16;
    if (int'(m_tpr) / 16 >= ic) return int'(m_tpr);
    return ic * 16;
  endfunction

  function automatic bit m_irq();
    int h = m_hi(m_irr);
    return m_svr[8] && h >= 0 && (h / 16) > (m_ppr() / 16);
  endfunction

  function automatic bit m_legal(input int o);
    return (o == 8 || o == 10 || o == 11 || o == 15 || (o >= 16 && o <= 40));
  endfunction

  function automatic logic [31:0] m_read(input int o);
    if (o == 8)  return 32'(m_tpr);
    if (o == 10) return 32'(m_ppr());
    if (o == 15) return 32'(m_svr);
    if (o == 40) return 32'(m_esr);
    if (o >= 16 && o < 24) return m_isr[(o-16)*32 +: 32];
    if (o >= 24 && o < 32) return m_tmr[(o-24)*32 +: 32];
    if (o >= 32 && o < 40) return m_irr[(o-32)*32 +: 32];
    return 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one-cycle operation; starts and ends at a falling edge
  task automatic op(input string req, input bit di, input int v, input bit lvl,
                    input bit da, input bit dw, input bit dr, input int o,
                    input logic [31:0] wd);
    int h  = m_hi(m_irr);
    int hs = m_hi(m_isr);
    bit fire = da && m_svr[8] && h >= 0;
    logic [31:0] rexp = m_legal(o) ? m_read(o) : 32'h0;
    inj_valid = di; inj_vector = 8'(v); inj_level = lvl;
    ack_req = da; reg_wr = dw; reg_rd = dr; reg_ofs = 8'(o); reg_wdata = wd;
    #1;
    if (da) begin
      check({req, " ack_spurious"}, 32'(ack_spurious), 32'(!fire));
      check({req, " ack_vector"}, 32'(ack_vector), fire ? 32'(h) : 32'(m_svr[7:0]));
    end
    if (dr) check({req, " rdata"}, reg_rdata, rexp);
    @(posedge clk); #1;
    inj_valid = 0; ack_req = 0; reg_wr = 0; reg_rd = 0;
    if (fire) m_irr[h] = 0;
    if (di) begin m_irr[v] = 1; m_tmr[v] = lvl; end
    if (dw && o == 11 && hs >= 0) m_isr[hs] = 0;
    if (fire) m_isr[h] = 1;
    if (dw && o == 8) m_tpr = wd[7:0];
    if (dw && o == 15) m_svr = wd[8:0];
    if ((dw || dr) && !m_legal(o)) m_esr[7] = 1;
    @(negedge clk);
    check({req, " irq"}, 32'(irq), 32'(m_irq()));
  endtask

  task automatic rd(input string req, input int o);
    op(req, 0, 0, 0, 0, 0, 1, o, 0);
  endtask
  task automatic wr(input string req, input int o, input logic [31:0] d);
    op(req, 0, 0, 0, 0, 1, 0, o, d);
  endtask
  task automatic inj(input string req, input int v, input bit l);
    op(req, 1, v, l, 0, 0, 0, 0, 0);
  endtask
  task automatic ack(input string req);
    op(req, 0, 0, 0, 1, 0, 0, 0, 0);
  endtask

  initial begin
    #600000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1a71));
    m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = 0; m_svr = 9'h0ff; m_esr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    rd("R1 tpr", 8); rd("R1 svr", 15); rd("R1 esr", 40); rd("R1 ppr", 10);
    for (int w = 16; w < 40; w++) rd("R1 vectors", w);
    // R2 injection while disabled, R5 no irq
    inj("R2 edge", 8'h45, 0);
    rd("R2 irr word", 34); rd("R2 tmr word", 26);
    inj("R2 level", 8'h07, 1);
    rd("R2 tmr lvl", 24); rd("R2 irr lvl", 32);
    ack("R7 disabled");
    // R9 enable, R5 irq rises
    wr("R9 svr", 15, 32'hffff_f13f); rd("R9 svr read", 15);
    wr("R5 tpr above", 8, 32'h50); wr("R5 tpr equal", 8, 32'h4f);
    wr("R9 tpr", 8, 32'hffff_ff30); rd("R9 tpr read", 8);
    // R6 ack, R3 highest, R4 ppr
    inj("R3 second", 8'ha2, 1);
    ack("R6 ack hi"); rd("R6 isr word", 21); rd("R6 irr word", 37);
    rd("R4 ppr from isr", 10);
    wr("R4 tpr high", 8, 32'hb7); rd("R4 ppr from tpr", 10);
    wr("R4 tpr low", 8, 32'h00);
    // R8 end of interrupt
    wr("R8 eoi", 11, 0); rd("R8 isr cleared", 21); rd("R8 eoi read", 11);
    ack("R6 ack next"); ack("R6 ack last");
    wr("R8 eoi a", 11, 0); wr("R8 eoi b", 11, 0); wr("R8 eoi empty", 11, 0);
    rd("R8 isr empty", 16); ack("R7 empty");
    // R11 writes to read-only offsets
    inj("R11 setup", 8'h21, 0);
    wr("R11 irr ro", 33, 32'hffff_ffff); wr("R11 ppr ro", 10, 32'hff);
    wr("R11 esr ro", 40, 32'hff);
    rd("R11 irr kept", 33); rd("R11 esr zero", 40); rd("R11 ppr kept", 10);
    // R10 illegal offsets
    rd("R10 illegal read", 8'h30); rd("R10 esr set", 40);
    wr("R10 illegal write", 8'h02, 32'h1); rd("R10 esr sticky", 40);
    // R12 same-cycle combinations
    ack("R12 drain");
    inj("R12 pre", 8'h70, 0);
    op("R12 inj wins", 1, 8'h70, 1, 1, 0, 0, 0, 0);
    rd("R12 irr kept", 35); rd("R12 isr set", 19);
    op("R12 eoi ack", 0, 0, 0, 1, 1, 0, 11, 0);
    rd("R12 isr after", 19); rd("R12 irr after", 35);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 9);
      case (k)
        0, 1, 2: inj("R2 rnd", $urandom_range(0, 255), 1'($urandom));
        3, 4:    ack("R6 rnd");
        5:       wr("R8 rnd", 11, 0);
        6:       wr("R9 rnd tpr", 8, $urandom);
        7:       wr("R9 rnd svr", 15, {$urandom_range(0, 3) != 0 ? 24'h1 : 24'h0, 8'($urandom)});
        8:       rd("R4 rnd ppr", 10);
        default: rd("R10 rnd rd", $urandom_range(0, 63));
      endcase
      if (i % 7 == 0)
        op("R12 rnd", 1, $urandom_range(0, 255), 1'($urandom), 1, 1, 0, 11, 0);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule